// File: doc/BRIEF.md
# Sub-Packet Mission Data Transmitter

This block buffers 16-bit words that software writes into it. When software issues a start command, it sends them serially to a downstream unit. Transmission begins only after the downstream unit drops its busy signal. The serial link is made of three wires: an enable that frames the packet, a bit clock, and a data line. Each word is sent most significant bit first.

A logical packet may be longer than the buffer. Software then sends it as a series of sub-packets. While the continuation bit is 1, the link stays open when the buffer drains: the enable stays high, no clock pulses are sent, and software can refill the buffer and start it again. Software marks the last sub-packet by writing 0 to both the start bit and the continuation bit. When that sub-packet drains, the enable drops and an active-low interrupt flag latches.

Software reaches the block through a 48-bit write bus, using a control write strobe and a data write strobe, and through a combinational status word.

Top module: `subpkt_md_tx`

## Requirements
- R1: A data write stores bits 31..16 of the write bus as one word at the tail of a first-in first-out buffer of DEPTH words. A data write to a full buffer is dropped.
- R2: Writing 0 to control bit 41 arms transmission. The enable `txEna` rises only in a cycle after one in which `busyIn` (active high) was low. While `busyIn` stays high, nothing is sent.
- R3: Each word goes out MSB first. Each bit lasts CLK_DIV clock cycles. `txClk` is low for the first half of each bit period and high for the second half, and `txData` stays stable while `txClk` is high. Consecutive buffered words are sent back to back.
- R4: Status bit 41 (start, active low) returns to 1 once the last buffered word has been shifted out.
- R5: If the buffer drains while status bit 42 (continuation) is 1, `txEna` stays high with no clock pulses and no interrupt. A later refill plus a start write resumes the same packet.
- R6: If the buffer drains while bit 42 is 0, `txEna` falls. In that same cycle the interrupt flag latches: `irqN` and status bit 43 both read 0. Writing 0 to control bit 43 clears the flag back to 1.
- R7: The status word carries flags in bits 47..40 and zeros in all lower bits. Bit 47 reads 0. Bit 46 is the full flag, active low. Bit 45 is the empty flag, active low. Bit 44 is `busyIn` as received. Bit 43 is the interrupt flag. Bit 42 is the continuation bit. Bit 41 is the start bit. Bit 40 reads 0.
- R8: A control write with bit 47 = 0 resets the interface. It empties the buffer, drops `txEna`, and returns start, continuation and interrupt flags to 1, so the status byte reads 0x4E with `busyIn` low. All other bits of that write are ignored.
- R9: Every non-reset control write loads the continuation bit from bit 42. Transmission never changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctlWr | input | 1 | Control register write strobe |
| dataWr | input | 1 | Buffer data write strobe |
| busWdata | input | 48 | Write bus: control in 47..40, data word in 31..16 |
| statusRdata | output | 48 | Status word: flags in 47..40, zero below |
| busyIn | input | 1 | Downstream busy, active high |
| txEna | output | 1 | Serial link enable, frames the packet |
| txClk | output | 1 | Serial bit clock |
| txData | output | 1 | Serial data, MSB first |
| irqN | output | 1 | Latched end-of-packet interrupt, active low |

## Verification
The bench builds the block with DEPTH = 8 and CLK_DIV = 2. This puts every buffer fill level from one word to completely full, plus the overflow case, within a few hundred cycles each. It sweeps all fill levels as single-sub-packet transfers. It decodes the serial line on each rising edge of `txClk` and compares every word against arithmetically generated values. The small depth also makes it cheap to cover the following cases:
- a two-sub-packet transfer with the link held open between refills;
- a start that waits on `busyIn`;
- an interface reset issued over a half-filled buffer.

// File: rtl/subpkt_md_tx_pkg.sv
package subpkt_md_tx_pkg;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic clear;     // interface reset: empty buffer, idle shifter
    logic loadWord;  // pop head word into shift register
    logic shiftEn;   // shifter running this cycle
  } dpStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_HOLD = 2'd2
  } txState_t;
endpackage

// File: rtl/subpkt_md_tx_dp.sv
module subpkt_md_tx_dp
  import subpkt_md_tx_pkg::*;
#(
  parameter int DEPTH   = 4096,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic              dataWr,
  input  logic [WORD_W-1:0] wrWord,
  output logic              bufFull,
  output logic              bufEmpty,
  output logic              wordDone,
  output logic              txClk,
  output logic              txData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [DIV_W-1:0] LAST_DIV = DIV_W'(CLK_DIV - 1);
  localparam logic [DIV_W-1:0] HALF_DIV = DIV_W'(CLK_DIV / 2);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic [WORD_W-1:0] shiftReg;
  logic [DIV_W-1:0]  divCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              push, pop;

  assign bufFull  = (count == FULL_CNT);
  assign bufEmpty = (count == '0);
  assign push     = dataWr && !bufFull && !strobes.clear;
  assign pop      = strobes.loadWord && !bufEmpty && !strobes.clear;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strobes.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      divCnt   <= '0;
      bitCnt   <= '0;
    end else if (strobes.clear) begin
      shiftReg <= '0;
      divCnt   <= '0;
      bitCnt   <= '0;
    end else if (pop) begin
      shiftReg <= mem[rdPtr];
      divCnt   <= '0;
      bitCnt   <= '0;
    end else if (strobes.shiftEn) begin
      if (divCnt == LAST_DIV) begin
        divCnt   <= '0;
        shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
        bitCnt   <= bitCnt + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign wordDone = strobes.shiftEn && (divCnt == LAST_DIV) && (bitCnt == LAST_BIT);
  assign txClk    = strobes.shiftEn && (divCnt >= HALF_DIV);
  assign txData   = strobes.shiftEn && shiftReg[WORD_W-1];
endmodule

// File: rtl/subpkt_md_tx_ctrl.sv
module subpkt_md_tx_ctrl
  import subpkt_md_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlWr,
  input  logic       ctlRstN,
  input  logic       ctlClrIrqN,
  input  logic       ctlEopN,
  input  logic       ctlStartN,
  input  logic       busyIn,
  input  logic       bufEmpty,
  input  logic       wordDone,
  output dpStrobes_t strobes,
  output logic       txEna,
  output logic       startN,
  output logic       eopN,
  output logic       irqN
);
  txState_t state;
  logic     irqFlag;
  logic     resetWr, go, lastDrain, irqSet;

  assign resetWr   = ctlWr && !ctlRstN;
  assign go        = !startN && !busyIn && !bufEmpty;
  assign lastDrain = (state == ST_SEND) && wordDone && bufEmpty;
  assign irqSet    = lastDrain && !eopN;

  always_comb begin
    strobes          = '0;
    strobes.clear    = resetWr;
    strobes.shiftEn  = (state == ST_SEND);
    strobes.loadWord = ((state != ST_SEND) && go) ||
                       ((state == ST_SEND) && wordDone && !bufEmpty);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      startN  <= 1'b1;
      eopN    <= 1'b1;
      irqFlag <= 1'b0;
    end else if (resetWr) begin
      state   <= ST_IDLE;
      startN  <= 1'b1;
      eopN    <= 1'b1;
      irqFlag <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (go) state <= ST_SEND;
        ST_HOLD: if (go) state <= ST_SEND;
        ST_SEND: begin
          if (lastDrain) begin
            startN <= 1'b1;
            state  <= eopN ? ST_HOLD : ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (irqSet) irqFlag <= 1'b1;
      if (ctlWr) begin
        eopN <= ctlEopN;
        if (!ctlStartN) startN <= 1'b0;
        if (!ctlClrIrqN && !irqSet) irqFlag <= 1'b0;
      end
    end
  end

  assign txEna = (state != ST_IDLE);
  assign irqN  = !irqFlag;
endmodule

// File: rtl/subpkt_md_tx.sv
module subpkt_md_tx
  import subpkt_md_tx_pkg::*;
#(
  parameter int DEPTH   = 4096,
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctlWr,
  input  logic        dataWr,
  input  logic [47:0] busWdata,
  output logic [47:0] statusRdata,
  input  logic        busyIn,
  output logic        txEna,
  output logic        txClk,
  output logic        txData,
  output logic        irqN
);
  dpStrobes_t strobes;
  logic bufFull, bufEmpty, wordDone, startN, eopN;
  logic unusedBits;

  assign unusedBits = ^{busWdata[46:44], busWdata[40:32], busWdata[15:0]};

  subpkt_md_tx_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctlWr      (ctlWr),
    .ctlRstN    (busWdata[47]),
    .ctlClrIrqN (busWdata[43]),
    .ctlEopN    (busWdata[42]),
    .ctlStartN  (busWdata[41]),
    .busyIn     (busyIn),
    .bufEmpty   (bufEmpty),
    .wordDone   (wordDone),
    .strobes    (strobes),
    .txEna      (txEna),
    .startN     (startN),
    .eopN       (eopN),
    .irqN       (irqN)
  );

  subpkt_md_tx_dp #(.DEPTH(DEPTH), .CLK_DIV(CLK_DIV)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .dataWr   (dataWr),
    .wrWord   (busWdata[31:16]),
    .bufFull  (bufFull),
    .bufEmpty (bufEmpty),
    .wordDone (wordDone),
    .txClk    (txClk),
    .txData   (txData)
  );

  assign statusRdata = {1'b0, !bufFull, !bufEmpty, busyIn, irqN, eopN, startN, 1'b0, 40'd0};
endmodule

// File: rtl/subpkt_md_tx_chk.sv
module subpkt_md_tx_chk (
  input logic        clk,
  input logic        rstN,
  input logic        ctlWr,
  input logic [47:0] busWdata,
  input logic [47:0] statusRdata,
  input logic        busyIn,
  input logic        txEna,
  input logic        txClk,
  input logic        txData,
  input logic        irqN
);
  logic resetWr;
  assign resetWr = ctlWr && !busWdata[47];

  // R2
  start_after_idle_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEna) |-> !$past(busyIn));

  // R3
  clk_inside_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    txClk |-> txEna);

  // R3
  data_stable_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txClk && $past(txClk)) |-> $stable(txData));

  // R4
  start_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEna) |-> statusRdata[41]);

  // R6
  irq_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(txEna) && !$past(resetWr)) |-> (!irqN && !statusRdata[43]));

  // R7
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!statusRdata[46] && !statusRdata[45]));

  // R8
  reset_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetWr |=> (!txEna && !statusRdata[45] && irqN && statusRdata[42]));
endmodule

bind subpkt_md_tx subpkt_md_tx_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .ctlWr       (ctlWr),
  .busWdata    (busWdata),
  .statusRdata (statusRdata),
  .busyIn      (busyIn),
  .txEna       (txEna),
  .txClk       (txClk),
  .txData      (txData),
  .irqN        (irqN)
);

// File: tb/subpkt_md_tx_tb_top.sv
`timescale 1ns/1ps
module subpkt_md_tx_tb_top;
  localparam int DEPTH = 8;
  localparam int DIV   = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlWr = 1'b0;
  logic        dataWr = 1'b0;
  logic [47:0] busWdata = '0;
  logic [47:0] statusRdata;
  logic        busyIn = 1'b0;
  logic        txEna, txClk, txData, irqN;

  int errors = 0;
  int checks = 0;
  longint cycles = 0;
  logic finished = 1'b0;

  logic [15:0] rxWords [64];
  int          rxCount = 0;
  logic [15:0] rxShift = '0;
  int          rxBits = 0;
  logic        prevTxClk = 1'b0;

  subpkt_md_tx #(.DEPTH(DEPTH), .CLK_DIV(DIV)) dut_i (
    .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .dataWr(dataWr),
    .busWdata(busWdata), .statusRdata(statusRdata), .busyIn(busyIn),
    .txEna(txEna), .txClk(txClk), .txData(txData), .irqN(irqN)
  );

  always #5 clk = ~clk;

  // serial receiver: capture on each rising edge of txClk, sampled mid-cycle
  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (txClk && !prevTxClk) begin
      if (rxBits == 15) begin
        if (rxCount < 64) rxWords[rxCount] = {rxShift[14:0], txData};
        rxCount = rxCount + 1;
        rxBits = 0;
      end else begin
        rxShift = {rxShift[14:0], txData};
        rxBits = rxBits + 1;
      end
    end
    prevTxClk = txClk;
  end

  function automatic logic [15:0] wordFor(int seed, int k);
    return 16'(32'h9C31 + seed * 32'h0B57 + k * 32'h1F0D);
  endfunction

  function automatic logic [47:0] ctlWord(logic rN, logic clrN, logic eN, logic sN);
    return {rN, 3'b111, clrN, eN, sN, 1'b1, 40'd0};
  endfunction

  task automatic check(string req, longint actual, longint expected, string what);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, actual, expected);
    end
  endtask

  task automatic writeCtl(logic [47:0] v);
    @(negedge clk); busWdata = v; ctlWr = 1'b1;
    @(negedge clk); ctlWr = 1'b0; busWdata = '0;
  endtask

  task automatic writeData(logic [15:0] w);
    @(negedge clk); busWdata = {16'd0, w, 16'd0}; dataWr = 1'b1;
    @(negedge clk); dataWr = 1'b0; busWdata = '0;
  endtask

  task automatic clearRx();
    rxCount = 0; rxBits = 0;
  endtask

  task automatic waitLow(int limit);
    for (int i = 0; i < limit && txEna; i++) @(negedge clk);
  endtask

  task automatic waitStartRelease(int limit);
    for (int i = 0; i < limit && !statusRdata[41]; i++) @(negedge clk);
  endtask

  task automatic checkWords(string req, int seed, int first, int n);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < n; k++) if (rxWords[first + k] !== wordFor(seed, k)) ok = 1'b0;
    check(req, ok, 1, "received word sequence");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R7 R8: power-on status byte 0x4E, link idle
    check("R7", statusRdata[47:40], 8'h4E, "reset status byte");
    check("R7", statusRdata[39:0], 0, "low status bits");
    check("R6", irqN, 1, "reset irqN");

    // R1 R3 R4 R6: sweep every fill level as a final sub-packet
    for (int n = 1; n <= DEPTH; n++) begin
      clearRx();
      for (int k = 0; k < n; k++) writeData(wordFor(n, k));
      check("R1", statusRdata[45], 1, "not empty after fill");
      check("R1", statusRdata[46], (n == DEPTH) ? 0 : 1, "full flag at fill level");
      writeCtl(ctlWord(1, 1, 0, 0));
      repeat (2) @(negedge clk);
      check("R2", txEna, 1, "link enabled after start");
      waitLow(n * 16 * DIV + 20);
      check("R3", rxCount, n, "word count");
      checkWords("R3", n, 0, n);
      check("R6", irqN, 0, "irq latched after final sub-packet");
      check("R6", statusRdata[43], 0, "status irq bit");
      check("R4", statusRdata[41], 1, "start released");
      check("R9", statusRdata[42], 0, "continuation bit held as written");
      writeCtl(ctlWord(1, 0, 1, 1));
      check("R6", irqN, 1, "irq cleared by bit 43");
    end

    // R1: overflow drops extra words
    clearRx();
    for (int k = 0; k < DEPTH + 3; k++) writeData(wordFor(40, k));
    check("R1", statusRdata[46], 0, "full flag");
    writeCtl(ctlWord(1, 1, 0, 0));
    repeat (2) @(negedge clk);
    waitLow(DEPTH * 16 * DIV + 40);
    check("R1", rxCount, DEPTH, "overflow words dropped");
    checkWords("R1", 40, 0, DEPTH);
    writeCtl(ctlWord(1, 0, 1, 1));

    // R2: busy holds off transmission
    clearRx();
    busyIn = 1'b1;
    writeData(wordFor(50, 0));
    writeData(wordFor(50, 1));
    writeCtl(ctlWord(1, 1, 0, 0));
    repeat (30) @(negedge clk);
    check("R2", txEna, 0, "no start while busy");
    check("R7", statusRdata[44], 1, "busy in status");
    check("R2", rxCount, 0, "nothing sent while busy");
    busyIn = 1'b0;
    repeat (3) @(negedge clk);
    check("R2", txEna, 1, "start after busy drops");
    waitLow(2 * 16 * DIV + 20);
    check("R2", rxCount, 2, "words after busy release");
    checkWords("R2", 50, 0, 2);
    writeCtl(ctlWord(1, 0, 1, 1));

    // R5 R9: two sub-packets with link held open
    clearRx();
    for (int k = 0; k < 3; k++) writeData(wordFor(60, k));
    writeCtl(ctlWord(1, 1, 1, 0));
    repeat (2) @(negedge clk);
    waitStartRelease(3 * 16 * DIV + 20);
    repeat (10) @(negedge clk);
    check("R5", txEna, 1, "link held open between sub-packets");
    check("R5", irqN, 1, "no irq between sub-packets");
    check("R5", rxCount, 3, "first sub-packet words");
    check("R9", statusRdata[42], 1, "continuation bit kept");
    check("R5", txClk, 0, "no clock while holding");
    for (int k = 3; k < 5; k++) writeData(wordFor(60, k));
    writeCtl(ctlWord(1, 1, 0, 0));
    repeat (2) @(negedge clk);
    waitLow(2 * 16 * DIV + 20);
    check("R5", rxCount, 5, "whole packet word count");
    checkWords("R5", 60, 0, 5);
    check("R6", irqN, 0, "irq after last sub-packet");
    writeCtl(ctlWord(1, 0, 1, 1));

    // R8: reset write over a half-filled buffer, other bits ignored
    clearRx();
    for (int k = 0; k < 4; k++) writeData(wordFor(70, k));
    writeCtl(ctlWord(0, 0, 0, 0));
    @(negedge clk);
    check("R8", statusRdata[47:40], 8'h4E, "status after reset write");
    repeat (20) @(negedge clk);
    check("R8", txEna, 0, "no transmission after reset write");
    check("R8", rxCount, 0, "buffer discarded");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule